// File: doc/BRIEF.md
# External Data Transfer Router

This block serves the data-transfer instructions of a small 8-bit CPU core, the ones that move bytes to and from the data-memory space. For every request it decides whether the byte lives in an on-chip auxiliary RAM or must be fetched or stored over a multiplexed external bus. The decision depends on three things: a bus-select control bit, a two-bit field that sets how much of the on-chip RAM is visible, and the pointer mode of the request. The pointer mode is either an 8-bit register pointer or a 16-bit data pointer.

An on-chip access takes one clock and leaves every external pin alone. An external access follows a fixed sequence. The low address goes onto the shared address/data port and is latched by a one-clock strobe. Then the data is either driven or released, and an active-low read or write strobe is held for 6 clocks, or for 30 clocks when the stretch bit is set, for slow peripherals. A 16-bit pointer access also drives the high address byte on a dedicated port. An 8-bit pointer access leaves that port unchanged, so software can use it as a page register.

Top module: `xdata_router`

## Requirements
- R1: With `ext_sel`=0 and the effective address below the visible size, the access is on-chip. `ram_en` is high in the request cycle, with `ram_addr` equal to the effective address and `ram_we` equal to `wr`. `done` is high on the following cycle, and a read returns `ram_rdata` on `rdata`.
- R2: An on-chip access leaves `bus_ad_oe` at 0, `ale` at 0, `rd_n` and `wr_n` at 1, and `bus_hi` unchanged.
- R3: With `ptr16`=0 the effective address is {8'h00, addr[7:0]}, and `addr[15:8]` is ignored.
- R4: With `ext_sel`=0, `ptr16`=1 and the address at or above the visible size, the access goes to the external bus.
- R5: With `ext_sel`=1, every access goes to the external bus, whatever its address or pointer mode.
- R6: `hide_sz` values 0, 1, 2 and 3 select a visible size of SIZE0, SIZE1, SIZE2 or SIZE3 bytes respectively (defaults 256, 512, 768 and 1024).
- R7: An external access begins with one clock of `ale`=1, `bus_ad_oe`=1 and `bus_ad_out`=addr[7:0]. When `ptr16`=1, `bus_hi` holds addr[15:8] from that clock onward.
- R8: An external access with `ptr16`=0 leaves `bus_hi` at its previous value.
- R9: After `ale`, the strobe is held low for 6 clocks when `stretch`=0, or 30 clocks when `stretch`=1. A read uses `rd_n` with `bus_ad_oe`=0. A write uses `wr_n` with `bus_ad_oe`=1 and `bus_ad_out`=wdata. The two strobes are never low together.
- R10: An external read samples `bus_ad_in` on the last strobe clock. `done` is high on the next clock, with that byte on `rdata`.
- R11: A request is accepted only while the block is idle; requests at any other time, including the `done` cycle, are ignored. `done` is high for exactly one clock per accepted access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request strobe |
| wr | input | 1 | 1 = write, 0 = read |
| ptr16 | input | 1 | 1 = 16-bit data pointer, 0 = 8-bit register pointer |
| addr | input | 16 | Access address |
| wdata | input | 8 | Write data |
| ext_sel | input | 1 | 1 = all accesses external |
| hide_sz | input | 2 | Visible on-chip size select |
| stretch | input | 1 | 1 = 30-clock strobe, 0 = 6-clock strobe |
| ram_en | output | 1 | On-chip RAM enable |
| ram_we | output | 1 | On-chip RAM write enable |
| ram_addr | output | 10 | On-chip RAM address |
| ram_wdata | output | 8 | On-chip RAM write data |
| ram_rdata | input | 8 | On-chip RAM read data (one clock after enable) |
| bus_ad_out | output | 8 | Multiplexed low address / write data |
| bus_ad_oe | output | 1 | Drive enable for the multiplexed port |
| bus_ad_in | input | 8 | Read data from the multiplexed port |
| bus_hi | output | 8 | High address byte |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| rdata | output | 8 | Read data, valid with done |
| done | output | 1 | One-clock completion pulse |

## Verification
Two things can fall in the same clock: the completion of one access and the arrival of the next request. A request also arrives while a strobe is running. To provoke both, the bench raises `req` in the middle of the strobe and again in the exact cycle `done` is high, each time with an address that would otherwise go on-chip. It then judges the result at the ports. `ram_en` must stay low, only one `done` may appear in the window, and the read data and `bus_hi` must belong to the first access.

// File: rtl/xdata_pkg.sv
package xdata_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RAM,
        ST_ALE,
        ST_STB,
        ST_END
    } xstate_e;

    // Request fields held for the length of an external transfer
    typedef struct packed {
        logic       wr;
        logic       long_stb;
        logic [7:0] lo;
        logic [7:0] wdata;
    } xreq_t;

    // An 8-bit pointer can only form the bottom page
    function automatic logic [15:0] eff_addr(input logic ptr16, input logic [15:0] a);
        return ptr16 ? a : {8'h00, a[7:0]};
    endfunction

endpackage

// File: rtl/xdata_route.sv
module xdata_route #(
    parameter int SIZE0 = 256,
    parameter int SIZE1 = 512,
    parameter int SIZE2 = 768,
    parameter int SIZE3 = 1024
) (
    input  logic        ext_sel,
    input  logic [1:0]  hide_sz,
    input  logic [15:0] ea,
    output logic        onchip
);
    localparam int NSZ = 4;
    localparam logic [16:0] VIS [NSZ] = '{17'(SIZE0), 17'(SIZE1), 17'(SIZE2), 17'(SIZE3)};

    logic [NSZ-1:0] fits;

    // One comparator per selectable window size
    for (genvar g = 0; g < NSZ; g++) begin : g_win
        assign fits[g] = ({1'b0, ea} < VIS[g]);
    end

    assign onchip = !ext_sel && fits[hide_sz];

endmodule

// File: rtl/xdata_bus_seq.sv
module xdata_bus_seq
    import xdata_pkg::*;
#(
    parameter int STB_SHORT = 6,
    parameter int STB_LONG  = 30
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req,
    input  logic        onchip,
    input  logic        wr,
    input  logic        ptr16,
    input  logic        stretch,
    input  logic [15:0] addr,
    input  logic [7:0]  wdata,
    input  logic [7:0]  bus_ad_in,
    input  logic [7:0]  ram_rdata,
    output logic        ram_go,
    output logic [7:0]  bus_ad_out,
    output logic        bus_ad_oe,
    output logic [7:0]  bus_hi,
    output logic        ale,
    output logic        rd_n,
    output logic        wr_n,
    output logic [7:0]  rdata,
    output logic        done
);
    localparam int CW = $clog2(STB_LONG + 1);

    xstate_e        st;
    xreq_t          cur;
    logic [CW-1:0]  cnt;
    logic [7:0]     hi_q;
    logic [7:0]     rd_q;
    logic           take;

    assign take   = req && (st == ST_IDLE);
    assign ram_go = take && onchip;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            cur  <= '0;
            cnt  <= '0;
            hi_q <= '0;
            rd_q <= '0;
        end else begin
            case (st)
                ST_IDLE: if (take) begin
                    cur.wr       <= wr;
                    cur.long_stb <= stretch;
                    cur.lo       <= addr[7:0];
                    cur.wdata    <= wdata;
                    if (onchip) begin
                        st <= ST_RAM;
                    end else begin
                        st <= ST_ALE;
                        if (ptr16) hi_q <= addr[15:8];
                    end
                end
                ST_RAM:  st <= ST_IDLE;
                ST_ALE: begin
                    st  <= ST_STB;
                    cnt <= cur.long_stb ? CW'(STB_LONG - 1) : CW'(STB_SHORT - 1);
                end
                ST_STB: begin
                    if (cnt == '0) begin
                        if (!cur.wr) rd_q <= bus_ad_in;
                        st <= ST_END;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_END:  st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign ale        = (st == ST_ALE);
    assign bus_ad_out = (st == ST_ALE) ? cur.lo : cur.wdata;
    assign bus_ad_oe  = (st == ST_ALE) || ((st == ST_STB) && cur.wr);
    assign rd_n       = !((st == ST_STB) && !cur.wr);
    assign wr_n       = !((st == ST_STB) && cur.wr);
    assign bus_hi     = hi_q;
    assign done       = (st == ST_RAM) || (st == ST_END);
    assign rdata      = (st == ST_RAM) ? ram_rdata : rd_q;

endmodule

// File: rtl/xdata_router.sv
module xdata_router
    import xdata_pkg::*;
#(
    parameter int SIZE0     = 256,
    parameter int SIZE1     = 512,
    parameter int SIZE2     = 768,
    parameter int SIZE3     = 1024,
    parameter int STB_SHORT = 6,
    parameter int STB_LONG  = 30,
    localparam int RAM_AW   = $clog2(SIZE3)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              wr,
    input  logic              ptr16,
    input  logic [15:0]       addr,
    input  logic [7:0]        wdata,
    input  logic              ext_sel,
    input  logic [1:0]        hide_sz,
    input  logic              stretch,
    output logic              ram_en,
    output logic              ram_we,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [7:0]        ram_wdata,
    input  logic [7:0]        ram_rdata,
    output logic [7:0]        bus_ad_out,
    output logic              bus_ad_oe,
    input  logic [7:0]        bus_ad_in,
    output logic [7:0]        bus_hi,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic [7:0]        rdata,
    output logic              done
);
    logic [15:0] ea;
    logic        onchip;

    assign ea = eff_addr(ptr16, addr);

    xdata_route #(
        .SIZE0(SIZE0), .SIZE1(SIZE1), .SIZE2(SIZE2), .SIZE3(SIZE3)
    ) u_route (
        .ext_sel (ext_sel),
        .hide_sz (hide_sz),
        .ea      (ea),
        .onchip  (onchip)
    );

    xdata_bus_seq #(
        .STB_SHORT(STB_SHORT), .STB_LONG(STB_LONG)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .onchip     (onchip),
        .wr         (wr),
        .ptr16      (ptr16),
        .stretch    (stretch),
        .addr       (addr),
        .wdata      (wdata),
        .bus_ad_in  (bus_ad_in),
        .ram_rdata  (ram_rdata),
        .ram_go     (ram_en),
        .bus_ad_out (bus_ad_out),
        .bus_ad_oe  (bus_ad_oe),
        .bus_hi     (bus_hi),
        .ale        (ale),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .rdata      (rdata),
        .done       (done)
    );

    assign ram_we    = wr;
    assign ram_addr  = ea[RAM_AW-1:0];
    assign ram_wdata = wdata;

endmodule

// File: rtl/xdata_router_chk.sv
module xdata_router_chk #(
    parameter int SHORT_W = 6,
    parameter int LONG_W  = 30
) (
    input logic       clk,
    input logic       rst,
    input logic       ext_sel,
    input logic       ram_en,
    input logic       ale,
    input logic       rd_n,
    input logic       wr_n,
    input logic       bus_ad_oe,
    input logic [7:0] bus_hi,
    input logic       done
);
    localparam int CW = $clog2(LONG_W + 2);

    logic          stb_low;
    logic [CW-1:0] low_run;

    assign stb_low = !rd_n || !wr_n;

    always_ff @(posedge clk) begin
        if (rst)          low_run <= '0;
        else if (stb_low) low_run <= low_run + 1'b1;
        else              low_run <= '0;
    end

    // R1
    ram_done_chk: assert property (@(posedge clk) disable iff (rst)
        ram_en |=> done);

    // R5
    ext_forces_bus_chk: assert property (@(posedge clk) disable iff (rst)
        ram_en |-> !ext_sel);

    // R2
    onchip_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ram_en |=> (rd_n && wr_n && !ale && !bus_ad_oe && $stable(bus_hi)));

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));

    // R9
    strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
        (!stb_low && low_run != '0) |-> (low_run == CW'(SHORT_W) || low_run == CW'(LONG_W)));

    // R7
    ale_then_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        ale |=> (!ale && stb_low));

endmodule

bind xdata_router xdata_router_chk #(.SHORT_W(STB_SHORT), .LONG_W(STB_LONG)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ext_sel   (ext_sel),
    .ram_en    (ram_en),
    .ale       (ale),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .bus_ad_oe (bus_ad_oe),
    .bus_hi    (bus_hi),
    .done      (done)
);

// File: tb/tb_xdata_router.sv
`timescale 1ns/1ps
module tb_xdata_router;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0, wr = 1'b0, ptr16 = 1'b0, ext_sel = 1'b0, stretch = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [1:0]  hide_sz = '0;
    logic        ram_en, ram_we, bus_ad_oe, ale, rd_n, wr_n, done;
    logic [9:0]  ram_addr;
    logic [7:0]  ram_wdata, ram_rdata, bus_ad_out, bus_ad_in, bus_hi, rdata;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    xdata_router dut (
        .clk(clk), .rst(rst), .req(req), .wr(wr), .ptr16(ptr16), .addr(addr),
        .wdata(wdata), .ext_sel(ext_sel), .hide_sz(hide_sz), .stretch(stretch),
        .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .ram_rdata(ram_rdata), .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe),
        .bus_ad_in(bus_ad_in), .bus_hi(bus_hi), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
        .rdata(rdata), .done(done)
    );

    // On-chip RAM model: synchronous read, initial content low byte ^ C3
    logic [7:0] mem [1024];
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 1024; i++) mem[i] <= 8'(i) ^ 8'hC3;
        end else if (ram_en) begin
            if (ram_we) mem[ram_addr] <= ram_wdata;
            else        ram_rdata     <= mem[ram_addr];
        end
    end

    // External device: latches low address on ale, returns it ^ 5A, records writes
    logic [7:0] ext_lat = '0;
    logic [7:0] ext_wr  = '0;
    always @(posedge clk) begin
        if (ale)   ext_lat <= bus_ad_out;
        if (!wr_n) ext_wr  <= bus_ad_out;
    end
    assign bus_ad_in = ext_lat ^ 8'h5A;

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    typedef struct packed {
        logic        ext;
        logic        p16;
        logic [1:0]  hide;
        logic        str;
        logic        wr;
        logic [15:0] addr;
        logic [7:0]  wd;
        logic        on;
        logic [7:0]  hi;
        logic [7:0]  dat;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b1, 2'd0, 1'b0, 1'b1, 16'h0012, 8'hA1, 1'b1, 8'h00, 8'h00},
        '{1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 16'h0012, 8'h00, 1'b1, 8'h00, 8'hA1},
        '{1'b0, 1'b1, 2'd0, 1'b0, 1'b1, 16'h0150, 8'h33, 1'b0, 8'h01, 8'h33},
        '{1'b0, 1'b1, 2'd1, 1'b0, 1'b1, 16'h0150, 8'h44, 1'b1, 8'h01, 8'h00},
        '{1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 16'h0150, 8'h00, 1'b1, 8'h01, 8'h44},
        '{1'b0, 1'b1, 2'd3, 1'b0, 1'b0, 16'h03FE, 8'h00, 1'b1, 8'h01, 8'h3D},
        '{1'b0, 1'b1, 2'd2, 1'b1, 1'b0, 16'h0300, 8'h00, 1'b0, 8'h03, 8'h5A},
        '{1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 16'h7712, 8'h00, 1'b1, 8'h03, 8'hA1},
        '{1'b1, 1'b0, 2'd3, 1'b0, 1'b0, 16'h0020, 8'h00, 1'b0, 8'h03, 8'h7A},
        '{1'b1, 1'b1, 2'd3, 1'b1, 1'b1, 16'h0010, 8'h99, 1'b0, 8'h00, 8'h99},
        '{1'b1, 1'b1, 2'd3, 1'b0, 1'b0, 16'hABCD, 8'h00, 1'b0, 8'hAB, 8'h97},
        '{1'b0, 1'b1, 2'd2, 1'b0, 1'b0, 16'h02FF, 8'h00, 1'b1, 8'hAB, 8'h3C}
    };

    task automatic run_vec(input vec_t v);
        int low_c, ale_c, act_c, done_k, n;
        logic saw;
        logic [7:0] got;
        logic [9:0] exp_ra;
        low_c = 0; ale_c = 0; act_c = 0; done_k = 0; got = '0;
        n = v.str ? 30 : 6;
        exp_ra = v.p16 ? v.addr[9:0] : {2'b00, v.addr[7:0]};
        @(negedge clk);
        ext_sel = v.ext; ptr16 = v.p16; hide_sz = v.hide; stretch = v.str;
        wr = v.wr; addr = v.addr; wdata = v.wd; req = 1'b1;
        #1 saw = ram_en;
        chk(saw == v.on, "R6 route (R4 R5)", 32'(saw), 32'(v.on));
        if (v.on) chk(ram_addr == exp_ra && ram_we == v.wr, "R3 ram address", 32'(ram_addr), 32'(exp_ra));
        @(negedge clk);
        req = 1'b0;
        for (int k = 1; k <= 40; k++) begin
            if (k > 1) @(negedge clk);
            low_c += int'(!rd_n || !wr_n);
            ale_c += int'(ale);
            act_c += int'(ale || bus_ad_oe || !rd_n || !wr_n);
            if (done) begin
                done_k = k;
                got = rdata;
                break;
            end
        end
        chk(done_k == (v.on ? 1 : n + 2), "R1 done timing", 32'(done_k), 32'(v.on ? 1 : n + 2));
        chk(low_c == (v.on ? 0 : n), "R9 strobe width", 32'(low_c), 32'(v.on ? 0 : n));
        chk(ale_c == (v.on ? 0 : 1), "R7 ale pulse", 32'(ale_c), 32'(v.on ? 0 : 1));
        if (v.on) chk(act_c == 0, "R2 bus untouched", 32'(act_c), 32'd0);
        if (!v.wr) chk(got == v.dat, "R10 read data", 32'(got), 32'(v.dat));
        if (v.wr && !v.on) chk(ext_wr == v.dat, "R9 write data", 32'(ext_wr), 32'(v.dat));
        chk(bus_hi == v.hi, "R8 high address", 32'(bus_hi), 32'(v.hi));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int dones;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // Reset state
        chk(rd_n && wr_n && !ale && !done && !bus_ad_oe, "R11 reset idle", {rd_n, wr_n, ale, done, bus_ad_oe}, 32'h18);
        chk(bus_hi == 8'h00, "R7 reset high byte", 32'(bus_hi), 32'h0);

        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // Busy window: request mid-strobe and on the done cycle must be ignored
        @(negedge clk);
        ext_sel = 1'b1; ptr16 = 1'b1; wr = 1'b0; stretch = 1'b0; hide_sz = 2'd3;
        addr = 16'h1234; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        repeat (3) @(negedge clk);
        ext_sel = 1'b0; addr = 16'h0005; req = 1'b1;
        #1 chk(ram_en == 1'b0, "R11 busy ignore", 32'(ram_en), 32'h0);
        @(negedge clk);
        req = 1'b0;
        dones = 0;
        while (!done) @(negedge clk);
        dones = 1;
        chk(rdata == 8'h6E, "R10 busy read data", 32'(rdata), 32'h6E);
        req = 1'b1;
        #1 chk(ram_en == 1'b0, "R11 done-cycle ignore", 32'(ram_en), 32'h0);
        @(negedge clk);
        req = 1'b0;
        for (int k = 0; k < 20; k++) begin
            dones += int'(done);
            chk(!ale && rd_n, "R11 no extra access", {ale, rd_n}, 32'h1);
            @(negedge clk);
        end
        chk(dones == 1, "R11 single done", 32'(dones), 32'd1);
        chk(bus_hi == 8'h12, "R7 busy high byte", 32'(bus_hi), 32'h12);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule